// File: doc/BRIEF.md
# Dual Data Pointer Address Unit

This unit generates data-memory addresses for a small processor core from two software-visible 16-bit data pointers. Each access names one pointer and says whether that pointer is the source of a move (a load from memory) or its destination (a store to memory). It also names a modify mode: hold, step up by one or step down by one. The unit drives the address, the read enable, the write enable and the write data of an external 2K x 16 data SRAM. That SRAM starts at word address 0 and is contiguous. On the clock edge that ends the access, the unit updates the selected pointer.

The moment of the step depends on the direction. A load addresses memory with the pointer as it stands and applies the step afterwards. A store applies the step first and addresses memory with the stepped value. Software can load either pointer directly, and it can read both pointers at any time through dedicated outputs. The memory outputs are combinational from the access inputs and the current pointers. Pointer updates are registered.

Top module: `dpau_top`

## Requirements
- R1: After reset both pointers read 0x0000 on `ptr0Out` and `ptr1Out`. With `accValid` low, `memRdEn` and `memWrEn` are both 0.
- R2: A load (`accValid`=1, `accStore`=0) with `accMode`=0 (hold) drives `memRdEn`=1 and `memWrEn`=0 in the same cycle, with `memAddr` equal to the low 11 bits of the selected pointer. The pointer is unchanged after the edge.
- R3: A load with `accMode`=1 (step up) or `accMode`=2 (step down) addresses memory with the old pointer value. After the edge the pointer holds the old value plus or minus one.
- R4: A store (`accStore`=1) drives `memWrEn`=1, `memRdEn`=0 and `memWrData`=`storeData`. With `accMode`=0, `memAddr` is the low 11 bits of the selected pointer and the pointer is unchanged.
- R5: A store with `accMode`=1 or 2 addresses memory with the pointer plus or minus one. After the edge the pointer holds that same stepped value.
- R6: `accMode`=3 is reserved and behaves as hold for both loads and stores.
- R7: Pointer steps wrap modulo 2^16 (0xFFFF+1 = 0x0000, 0x0000-1 = 0xFFFF). `memAddr` always carries bits 10:0 of the addressing value.
- R8: A software write (`swWrEn`=1) loads `swData` into the pointer chosen by `swSel` (0 selects pointer 0, 1 selects pointer 1). The new value appears on that pointer's output after the edge.
- R9: When a software write and a stepping access target the same pointer in the same cycle, the software value is the one stored. The access still addresses memory from the pre-edge pointer. A step on the other pointer is applied normally.
- R10: An access through one pointer leaves the other pointer unchanged.
- R11: With `accValid` low, no memory enable is raised and no pointer changes, whatever the other access inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | An access is requested this cycle |
| accSel | input | 1 | Pointer used by the access (0 or 1) |
| accStore | input | 1 | 1: pointer is the destination (store); 0: source (load) |
| accMode | input | 2 | 0 hold, 1 step up, 2 step down, 3 reserved (hold) |
| storeData | input | 16 | Data to write on a store |
| swWrEn | input | 1 | Software write to a pointer |
| swSel | input | 1 | Pointer targeted by the software write |
| swData | input | 16 | Value for the software write |
| ptr0Out | output | 16 | Current value of pointer 0 |
| ptr1Out | output | 16 | Current value of pointer 1 |
| memAddr | output | 11 | SRAM word address |
| memRdEn | output | 1 | SRAM read enable |
| memWrEn | output | 1 | SRAM write enable |
| memWrData | output | 16 | SRAM write data |

## Verification
The hardest case to reach is a software write and a stepping access landing on the same pointer in the same cycle. The two paths must be told apart: the address has to follow the old pointer while the stored value follows the software data. The bench drives both in one cycle with distinct values and checks both `memAddr` and the pointer afterwards. It repeats this with the two paths on different pointers, so that the step on the other pointer is shown not to be suppressed. Wrap-around at both ends of the 16-bit range is reached by first loading a pointer with 0xFFFF or 0x0000 through the software write.

// File: rtl/dpau_pkg.sv
package dpau_pkg;
  localparam int PTR_CNT = 2;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2,
    MODE_RSVD = 2'd3
  } stepMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sel;      // pointer used by the access
    logic stepEn;   // apply a +/-1 step to the selected pointer
    logic stepDown; // step direction
    logic preStep;  // address with the stepped value (store)
    logic rdEn;
    logic wrEn;
  } dpStrobe_t;
endpackage

// File: rtl/dpau_ctrl.sv
module dpau_ctrl
  import dpau_pkg::*;
(
  input  logic       accValid,
  input  logic       accSel,
  input  logic       accStore,
  input  logic [1:0] accMode,
  output dpStrobe_t  strobe
);
  stepMode_e modeDec;

  always_comb begin
    modeDec = stepMode_e'(accMode);
    strobe.sel      = accSel;
    strobe.stepEn   = accValid && (modeDec == MODE_UP || modeDec == MODE_DOWN);
    strobe.stepDown = (modeDec == MODE_DOWN);
    strobe.preStep  = accStore;
    strobe.rdEn     = accValid && !accStore;
    strobe.wrEn     = accValid && accStore;
  end
endmodule

// File: rtl/dpau_dp.sv
module dpau_dp
  import dpau_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic                     swWrEn,
  input  logic                     swSel,
  input  logic [PTR_W-1:0]         swData,
  output logic [PTR_CNT-1:0][PTR_W-1:0] ptrQ,
  output logic [ADDR_W-1:0]        addr
);
  logic [PTR_W-1:0] selPtr;
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] addrFull;

  assign selPtr  = ptrQ[strobe.sel];
  assign stepped = strobe.stepDown ? selPtr - PTR_W'(1) : selPtr + PTR_W'(1);

  always_comb begin
    if (strobe.preStep && strobe.stepEn) addrFull = stepped;
    else                                  addrFull = selPtr;
  end
  assign addr = addrFull[ADDR_W-1:0];

  for (genvar i = 0; i < PTR_CNT; i++) begin : g_ptr
    logic swHit;
    logic stepHit;
    assign swHit   = swWrEn && (swSel == 1'(i));
    assign stepHit = strobe.stepEn && (strobe.sel == 1'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        ptrQ[i] <= '0;
      else if (swHit)   ptrQ[i] <= swData;
      else if (stepHit) ptrQ[i] <= stepped;
    end
  end
endmodule

// File: rtl/dpau_top.sv
module dpau_top
  import dpau_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accSel,
  input  logic              accStore,
  input  logic [1:0]        accMode,
  input  logic [DATA_W-1:0] storeData,
  input  logic              swWrEn,
  input  logic              swSel,
  input  logic [PTR_W-1:0]  swData,
  output logic [PTR_W-1:0]  ptr0Out,
  output logic [PTR_W-1:0]  ptr1Out,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData
);
  dpStrobe_t strobe;
  logic [PTR_CNT-1:0][PTR_W-1:0] ptrQ;

  dpau_ctrl u_ctrl (
    .accValid(accValid),
    .accSel  (accSel),
    .accStore(accStore),
    .accMode (accMode),
    .strobe  (strobe)
  );

  dpau_dp #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .swWrEn(swWrEn),
    .swSel (swSel),
    .swData(swData),
    .ptrQ  (ptrQ),
    .addr  (memAddr)
  );

  assign ptr0Out   = ptrQ[0];
  assign ptr1Out   = ptrQ[1];
  assign memRdEn   = strobe.rdEn;
  assign memWrEn   = strobe.wrEn;
  assign memWrData = storeData;
endmodule

// File: rtl/dpau_checker.sv
module dpau_checker #(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accSel,
  input logic              accStore,
  input logic [1:0]        accMode,
  input logic [DATA_W-1:0] storeData,
  input logic              swWrEn,
  input logic              swSel,
  input logic [PTR_W-1:0]  swData,
  input logic [PTR_W-1:0]  ptr0Out,
  input logic [PTR_W-1:0]  ptr1Out,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [DATA_W-1:0] memWrData
);
  logic [PTR_W-1:0] p0Up;
  assign p0Up = ptr0Out + PTR_W'(1);

  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!memRdEn && !memWrEn));

  assert_store_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData == storeData));

  assert_load_post_up_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accStore && accSel == 1'b0 && accMode == 2'd1 && !swWrEn)
      |=> (ptr0Out == $past(ptr0Out) + PTR_W'(1)));

  assert_store_pre_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accStore && accSel == 1'b0 && accMode == 2'd1)
      |-> (memAddr == p0Up[ADDR_W-1:0]));

  assert_sw_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && swSel == 1'b0) |=> (ptr0Out == $past(swData)));

  assert_other_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSel == 1'b1 && !swWrEn) |=> (ptr0Out == $past(ptr0Out)));

  assert_ptr1_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!accValid && !swWrEn) |=> (ptr1Out == $past(ptr1Out)));
endmodule

bind dpau_top dpau_checker #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accSel(accSel),
  .accStore(accStore), .accMode(accMode), .storeData(storeData),
  .swWrEn(swWrEn), .swSel(swSel), .swData(swData),
  .ptr0Out(ptr0Out), .ptr1Out(ptr1Out), .memAddr(memAddr),
  .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData)
);

// File: tb/dpau_top_bench.sv
`timescale 1ns/1ps
module dpau_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accSel = 1'b0, accStore = 1'b0;
  logic [1:0]  accMode = 2'd0;
  logic [15:0] storeData = '0;
  logic        swWrEn = 1'b0, swSel = 1'b0;
  logic [15:0] swData = '0;
  logic [15:0] ptr0Out, ptr1Out, memWrData;
  logic [10:0] memAddr;
  logic        memRdEn, memWrEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp0 = '0, exp1 = '0;

  always #5 clk = ~clk;

  dpau_top u_dpau_top (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSel(accSel),
    .accStore(accStore), .accMode(accMode), .storeData(storeData),
    .swWrEn(swWrEn), .swSel(swSel), .swData(swData),
    .ptr0Out(ptr0Out), .ptr1Out(ptr1Out), .memAddr(memAddr),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkPtrs(input string tag);
    chk({tag, " ptr0"}, ptr0Out, exp0);
    chk({tag, " ptr1"}, ptr1Out, exp1);
  endtask

  // one access cycle; checks memory side during the cycle, pointers after
  task automatic access(input string tag, input logic sel, input logic st,
                        input logic [1:0] mode, input logic [15:0] data);
    logic [15:0] cur, nxt, adr;
    cur = sel ? exp1 : exp0;
    nxt = (mode == 2'd1) ? cur + 16'd1 : (mode == 2'd2) ? cur - 16'd1 : cur;
    adr = st ? nxt : cur;
    @(negedge clk);
    accValid = 1'b1; accSel = sel; accStore = st; accMode = mode; storeData = data;
    #1;
    chk({tag, " addr"}, {5'd0, memAddr}, {5'd0, adr[10:0]});
    chk({tag, " rdEn"}, {15'd0, memRdEn}, {15'd0, !st});
    chk({tag, " wrEn"}, {15'd0, memWrEn}, {15'd0, st});
    if (st) chk({tag, " wrData"}, memWrData, data);
    if (sel) exp1 = nxt; else exp0 = nxt;
    @(negedge clk);
    accValid = 1'b0; accMode = 2'd0;
    #1;
    chkPtrs(tag);
  endtask

  task automatic swWrite(input string tag, input logic sel, input logic [15:0] val);
    @(negedge clk);
    swWrEn = 1'b1; swSel = sel; swData = val;
    @(negedge clk);
    swWrEn = 1'b0;
    if (sel) exp1 = val; else exp0 = val;
    #1;
    chkPtrs(tag);
  endtask

  task automatic testReset;
    #1;
    chkPtrs("R1 reset");
    chk("R1 rdEn idle", {15'd0, memRdEn}, 16'd0);
    chk("R1 wrEn idle", {15'd0, memWrEn}, 16'd0);
  endtask

  task automatic testLoads;
    swWrite("R8 sw write p0", 1'b0, 16'h0100);
    swWrite("R8 sw write p1", 1'b1, 16'h0200);
    access("R2 load hold p0", 1'b0, 1'b0, 2'd0, 16'h0);
    access("R3 load up p0", 1'b0, 1'b0, 2'd1, 16'h0);
    access("R3 R10 load down p1", 1'b1, 1'b0, 2'd2, 16'h0);
  endtask

  task automatic testStores;
    access("R4 store hold p1", 1'b1, 1'b1, 2'd0, 16'hA5A5);
    access("R5 store up p0", 1'b0, 1'b1, 2'd1, 16'h1234);
    access("R5 R10 store down p1", 1'b1, 1'b1, 2'd2, 16'hBEEF);
    access("R6 store reserved p0", 1'b0, 1'b1, 2'd3, 16'h0F0F);
    access("R6 load reserved p1", 1'b1, 1'b0, 2'd3, 16'h0);
  endtask

  task automatic testWrap;
    swWrite("R7 set p0 FFFF", 1'b0, 16'hFFFF);
    access("R7 store up wraps to 0", 1'b0, 1'b1, 2'd1, 16'h7777);
    access("R7 load down wraps to FFFF", 1'b0, 1'b0, 2'd2, 16'h0);
    swWrite("R7 set p1 0FFF", 1'b1, 16'h0FFF);
    access("R7 addr low bits", 1'b1, 1'b0, 2'd0, 16'h0);
  endtask

  task automatic testPriority;
    swWrite("R9 set p0", 1'b0, 16'h0010);
    @(negedge clk);
    accValid = 1'b1; accSel = 1'b0; accStore = 1'b0; accMode = 2'd1;
    swWrEn = 1'b1; swSel = 1'b0; swData = 16'h0055;
    #1;
    chk("R9 same ptr addr old", {5'd0, memAddr}, 16'h0010);
    @(negedge clk);
    accValid = 1'b0; swWrEn = 1'b0; accMode = 2'd0;
    exp0 = 16'h0055;
    #1;
    chkPtrs("R9 sw wins same ptr");
    @(negedge clk);
    accValid = 1'b1; accSel = 1'b1; accStore = 1'b1; accMode = 2'd1;
    swWrEn = 1'b1; swSel = 1'b0; swData = 16'h0123;
    #1;
    chk("R9 other ptr addr", {5'd0, memAddr}, {5'd0, 11'(exp1 + 16'd1)});
    @(negedge clk);
    accValid = 1'b0; swWrEn = 1'b0; accMode = 2'd0;
    exp0 = 16'h0123; exp1 = exp1 + 16'd1;
    #1;
    chkPtrs("R9 both paths apply");
  endtask

  task automatic testIdle;
    @(negedge clk);
    accValid = 1'b0; accSel = 1'b1; accStore = 1'b1; accMode = 2'd1;
    #1;
    chk("R11 idle rdEn", {15'd0, memRdEn}, 16'd0);
    chk("R11 idle wrEn", {15'd0, memWrEn}, 16'd0);
    @(negedge clk);
    accMode = 2'd2; accSel = 1'b0;
    @(negedge clk);
    accMode = 2'd0;
    #1;
    chkPtrs("R11 idle holds");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset;
    rstN = 1'b1;
    testLoads;
    testStores;
    testWrap;
    testPriority;
    testIdle;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule